// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block sits next to an SDRAM command controller and keeps the whole array refreshed on time. A free-running interval timer adds one owed refresh to a bounded credit counter each time an interval expires. The default interval is the clock rate times 64 ms divided by 8192 refreshes, which is 1039 clocks at 133 MHz. While credit is owed and the scheduler is idle, it asks the controller's arbiter for the command bus.

When the arbiter grants the bus, the scheduler samples whether the controller reports every bank as precharged. If so, it issues an auto refresh at once. If not, it first issues a precharge to all banks, waits the row-precharge time, and then refreshes. After each refresh it keeps the bus for the row-cycle time. If credit is still owed at the end of that time, it issues the next refresh without giving up the bus. Owed credit therefore drains as one back-to-back burst.

Credit saturates at a fixed ceiling. At that ceiling the scheduler flags urgency, so the arbiter can put refresh ahead of host traffic. The controller keeps the clock enable high. The scheduler drives the chip-select, row-strobe, column-strobe, write-enable and A10 lines only while its command-enable output is high.

Top module: `sdr_refresh_sched`

## Requirements
- R1: During and right after reset, ref_req, ref_busy, ref_urgent and cmd_en are low, and the command lines read deselect ({cs_n,ras_n,cas_n,we_n} = 1111, a10 = 0).
- R2: One refresh is owed every INTERVAL_CLKS clock edges after reset release. ref_req first goes high right after edge INTERVAL_CLKS and is low before it.
- R3: ref_req stays high while credit is owed and no grant has been taken. A grant is a rising edge with ref_req and ref_ack both high. ref_ack while ref_req is low starts nothing: ref_busy and cmd_en stay low.
- R4: A grant taken with banks_idle high puts an auto refresh ({cs_n,ras_n,cas_n,we_n} = 0001, cmd_en high) on the lines in the cycle right after the grant edge.
- R5: A grant taken with banks_idle low first drives precharge-all ({cs_n,ras_n,cas_n,we_n} = 0010, a10 = 1) in the cycle after the grant edge. The first auto refresh follows exactly TRP_CLKS cycles later.
- R6: Each auto refresh is followed by exactly TRC_CLKS cycles before the next refresh or the release of the bus. No command is driven in between.
- R7: One grant issues as many refreshes as credit is owed, back to back. Precharge-all is issued at most once per grant, and the bus is released only once credit is zero.
- R8: ref_busy is high from the first command cycle of a grant until TRC_CLKS cycles after its last refresh. ref_req is low while ref_busy is high.
- R9: Credit saturates at MAX_OWED, and ref_urgent is high exactly while credit equals MAX_OWED. Intervals that expire at saturation are lost: a grant then issues exactly MAX_OWED refreshes.
- R10: An interval that expires during a grant, before the last row-cycle wait ends, adds a refresh to the same burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| banks_idle | input | 1 | Controller reports all banks precharged; sampled at the grant edge |
| ref_ack | input | 1 | Arbiter grant for the refresh request |
| ref_req | output | 1 | Refresh requested (credit owed, scheduler idle) |
| ref_urgent | output | 1 | Credit at its ceiling; refresh should win over host traffic |
| ref_busy | output | 1 | Scheduler owns the command bus |
| cmd_en | output | 1 | Command lines below carry a scheduler command this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10 (high selects all banks on precharge) |

## Verification
The hardest situation to reach is an interval expiring inside the row-cycle wait of a grant. That expiry must extend the burst rather than raise a new request. The bench tracks its own count of edges since reset and places a grant exactly three edges before an interval boundary. The new credit then lands during the wait, and the bench expects a second refresh TRC_CLKS cycles after the first. Saturation is reached by withholding the grant for more intervals than the ceiling, then confirming that the burst length equals the ceiling.

// File: rtl/sdr_ref_pkg.sv
// Package: shared types for the refresh scheduler.
// Holds the sequencer state encoding and the command-line bundle with its
// fixed encodings {cs_n, ras_n, cas_n, we_n, a10}.
package sdr_ref_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_PRECH   = 3'd1,
        SQ_WAIT_RP = 3'd2,
        SQ_AREF    = 3'd3,
        SQ_WAIT_RC = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESEL   = 5'b1111_0;
    localparam sdr_cmd_t CMD_PRE_ALL = 5'b0010_1;
    localparam sdr_cmd_t CMD_AREF    = 5'b0001_0;

endpackage

// File: rtl/ref_interval_timer.sv
// Module: ref_interval_timer
// Free-running counter that pulses tick for one cycle every INTERVAL_CLKS
// clock edges. The first pulse is visible after edge INTERVAL_CLKS-1, so the
// credit it feeds changes at edge INTERVAL_CLKS.
// Assumes INTERVAL_CLKS >= 2.
module ref_interval_timer #(
    parameter int INTERVAL_CLKS = 1039
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL_CLKS > 1) ? $clog2(INTERVAL_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CLKS - 1);

    logic [CW-1:0] cnt;

    // Advance the interval count and wrap at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick marks the final cycle of each interval.
    always_comb begin
        tick = (cnt == LAST);
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("interval tick lasted more than one cycle");

endmodule

// File: rtl/ref_credit_counter.sv
// Module: ref_credit_counter
// Counts owed refreshes: +1 per interval tick and -1 per issued refresh,
// saturating at MAX_OWED. A tick arriving at the ceiling is dropped.
// Reports whether anything is owed and whether the ceiling is reached.
// Assumes consume is raised only while pending is high.
module ref_credit_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic consume,
    output logic pending,
    output logic urgent
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

    logic [OW-1:0] owed;

    // Update the owed count from interval ticks and issued refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({tick, consume})
                2'b10:   if (owed != CEIL) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    // Derive the request and urgency flags from the count.
    always_comb begin
        pending = (owed != '0);
        urgent  = (owed == CEIL);
    end

    // R9
    owed_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CEIL)
        else $error("owed credit above its ceiling");

    // R7
    consume_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> pending)
        else $error("refresh issued with no credit owed");

endmodule

// File: rtl/ref_cmd_sequencer.sv
// Module: ref_cmd_sequencer
// Request/grant state machine that owns the command lines during a refresh
// burst: an optional precharge-all, a wait of TRP_CLKS, then one auto refresh
// per owed credit, each followed by a wait of TRC_CLKS.
// Assumes TRP_CLKS >= 1 and TRC_CLKS >= 2, and that banks_idle is valid at
// the grant edge.
module ref_cmd_sequencer
    import sdr_ref_pkg::*;
#(
    parameter int TRP_CLKS = 2,
    parameter int TRC_CLKS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pending,
    input  logic     ack,
    input  logic     banks_idle,
    output logic     req,
    output logic     busy,
    output logic     consume,
    output logic     cmd_en,
    output sdr_cmd_t cmd
);
    localparam int DMAX = (TRP_CLKS > TRC_CLKS) ? TRP_CLKS : TRC_CLKS;
    localparam int DW   = $clog2(DMAX + 1);
    localparam logic [DW-1:0] RP_LOAD = DW'((TRP_CLKS >= 2) ? TRP_CLKS - 2 : 0);
    localparam logic [DW-1:0] RC_LOAD = DW'(TRC_CLKS - 2);
    localparam logic [DW-1:0] RC_FULL = DW'(TRC_CLKS);

    seq_state_t    state;
    logic [DW-1:0] dly;

    // Step through the precharge, refresh and wait phases of a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            dly   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (pending && ack) begin
                        state <= banks_idle ? SQ_AREF : SQ_PRECH;
                    end
                end
                SQ_PRECH: begin
                    dly   <= RP_LOAD;
                    state <= (TRP_CLKS <= 1) ? SQ_AREF : SQ_WAIT_RP;
                end
                SQ_WAIT_RP: begin
                    if (dly == '0) state <= SQ_AREF;
                    else           dly   <= dly - 1'b1;
                end
                SQ_AREF: begin
                    dly   <= RC_LOAD;
                    state <= SQ_WAIT_RC;
                end
                SQ_WAIT_RC: begin
                    if (dly == '0) state <= pending ? SQ_AREF : SQ_IDLE;
                    else           dly   <= dly - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode the handshake outputs and command lines from the state.
    always_comb begin
        req     = (state == SQ_IDLE) && pending;
        busy    = (state != SQ_IDLE);
        consume = (state == SQ_AREF);
        cmd_en  = (state == SQ_AREF) || (state == SQ_PRECH);
        unique case (state)
            SQ_PRECH: cmd = CMD_PRE_ALL;
            SQ_AREF:  cmd = CMD_AREF;
            default:  cmd = CMD_DESEL;
        endcase
    end

    // Checker-side count of cycles since the last refresh, capped at TRC_CLKS.
    logic [DW-1:0] since_ref;
    logic          ref_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= '0;
            ref_seen  <= 1'b0;
        end else if (state == SQ_AREF) begin
            since_ref <= DW'(1);
            ref_seen  <= 1'b1;
        end else if (since_ref < RC_FULL) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    // R6
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && ref_seen) |-> (since_ref == RC_FULL))
        else $error("command issued inside the row-cycle window");

    // R8
    req_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req)
        else $error("request raised while bus held");

    // R7
    drained_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!pending))
        else $error("bus released with credit still owed");

endmodule

// File: rtl/sdr_refresh_sched.sv
// Module: sdr_refresh_sched (top)
// Periodic refresh scheduler for an SDRAM command controller. Derives the
// refresh interval from the clock rate and a 64 ms / 8192 budget, keeps
// owed credit, and runs the precharge/refresh sequence on a req/ack grant.
// Assumes the controller holds clock enable high and yields the command
// lines to this block while ref_busy is high.
module sdr_refresh_sched
    import sdr_ref_pkg::*;
#(
    parameter int CLK_MHZ         = 133,
    parameter int WINDOW_MS       = 64,
    parameter int REFS_PER_WINDOW = 8192,
    parameter int TRC_NS          = 60,
    parameter int TRP_NS          = 15,
    parameter int MAX_OWED        = 8,
    parameter int INTERVAL_CLKS   = (CLK_MHZ * 1000 * WINDOW_MS) / REFS_PER_WINDOW,
    parameter int TRC_CLKS        = (TRC_NS * CLK_MHZ + 999) / 1000,
    parameter int TRP_CLKS        = (TRP_NS * CLK_MHZ + 999) / 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle,
    input  logic ref_ack,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic cmd_en,
    output logic cmd_cs_n,
    output logic cmd_ras_n,
    output logic cmd_cas_n,
    output logic cmd_we_n,
    output logic cmd_a10
);
    localparam int TRC_EFF = (TRC_CLKS < 2) ? 2 : TRC_CLKS;
    localparam int TRP_EFF = (TRP_CLKS < 1) ? 1 : TRP_CLKS;
    localparam int INT_EFF = (INTERVAL_CLKS < 2) ? 2 : INTERVAL_CLKS;

    logic     tick;
    logic     consume;
    logic     pending;
    sdr_cmd_t cmd;

    ref_interval_timer #(
        .INTERVAL_CLKS(INT_EFF)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ref_credit_counter #(
        .MAX_OWED(MAX_OWED)
    ) u_credit (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .consume(consume),
        .pending(pending),
        .urgent (ref_urgent)
    );

    ref_cmd_sequencer #(
        .TRP_CLKS(TRP_EFF),
        .TRC_CLKS(TRC_EFF)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .ack       (ref_ack),
        .banks_idle(banks_idle),
        .req       (ref_req),
        .busy      (ref_busy),
        .consume   (consume),
        .cmd_en    (cmd_en),
        .cmd       (cmd)
    );

    // Spread the command bundle onto the individual lines.
    always_comb begin
        cmd_cs_n  = cmd.cs_n;
        cmd_ras_n = cmd.ras_n;
        cmd_cas_n = cmd.cas_n;
        cmd_we_n  = cmd.we_n;
        cmd_a10   = cmd.a10;
    end

    // R9
    urgent_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || ref_busy))
        else $error("urgent credit neither requested nor being served");

    // R4
    refresh_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack && banks_idle) |=> (cmd_en && !cmd_cas_n && cmd_we_n))
        else $error("idle-bank grant did not refresh at once");

endmodule

// File: tb/tb_sdr_refresh_sched.sv
module tb_sdr_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int IV   = 20;
    localparam int TRC  = 4;
    localparam int TRP  = 2;
    localparam int MAXO = 4;
    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_PRE   = 4'b0010;
    localparam logic [3:0] C_REF   = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b0;
    logic ref_ack = 1'b0;
    logic ref_req, ref_urgent, ref_busy, cmd_en;
    logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wd = 0;

    sdr_refresh_sched #(
        .MAX_OWED(MAXO), .INTERVAL_CLKS(IV), .TRC_CLKS(TRC), .TRP_CLKS(TRP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_ack(ref_ack),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
        .cmd_en(cmd_en), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_a10(cmd_a10)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edges since reset release, the bench's own time base.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=<20000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string r, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", r, act, exp, cyc);
        end
    endtask

    function automatic int cmd_now();
        return int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n});
    endfunction

    task automatic wait_phase(input int p);
        do @(negedge clk); while ((cyc % IV) != p);
    endtask

    // Grant at this negedge, then walk the burst cycle by cycle.
    task automatic do_grant(input bit idle_v, input int n, input string tag);
        int o;
        int t_end;
        int ecmd;
        o = idle_v ? 0 : TRP;
        t_end = o + n * TRC;
        check("R3", int'(ref_req), 1);
        ref_ack = 1'b1;
        banks_idle = idle_v;
        @(negedge clk);
        ref_ack = 1'b0;
        banks_idle = 1'b0;
        for (int c = 0; c <= t_end; c++) begin
            ecmd = int'(C_DESEL);
            if (!idle_v && c == 0) ecmd = int'(C_PRE);
            else if (c >= o && c < t_end && ((c - o) % TRC) == 0) ecmd = int'(C_REF);
            if (ecmd == int'(C_PRE)) begin
                check("R5", cmd_now(), ecmd);
                check("R5", int'(cmd_a10), 1);
            end else begin
                check(tag, cmd_now(), ecmd);
            end
            check("R8", int'(cmd_en), (ecmd != int'(C_DESEL)) ? 1 : 0);
            check("R8", int'(ref_busy), (c < t_end) ? 1 : 0);
            if (c < t_end) check("R8", int'(ref_req), 0);
            if (c < t_end) @(negedge clk);
        end
        check("R7", int'(ref_req), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(ref_req), 0);
        check("R1", int'(ref_busy), 0);
        check("R1", int'(ref_urgent), 0);
        check("R1", int'(cmd_en), 0);
        check("R1", cmd_now(), int'(C_DESEL));
        check("R1", int'(cmd_a10), 0);
        rst_n = 1'b1;

        // R2: first request exactly IV edges after release; R3: stray ack ignored
        for (int k = 1; k <= IV; k++) begin
            @(negedge clk);
            check("R2", int'(ref_req), (k >= IV) ? 1 : 0);
            if (k == 5) ref_ack = 1'b1;
            if (k == 6) begin
                ref_ack = 1'b0;
                check("R3", int'(ref_busy), 0);
                check("R3", int'(cmd_en), 0);
            end
        end
        // R3: request held without grant
        repeat (3) begin
            @(negedge clk);
            check("R3", int'(ref_req), 1);
            check("R1", int'(ref_busy), 0);
        end

        // R4: idle banks, single refresh
        do_grant(1'b1, 1, "R4");

        // R5: banks open, precharge-all first
        wait_phase(0);
        check("R2", int'(ref_req), 1);
        do_grant(1'b0, 1, "R5");

        // R9: accumulate to the ceiling and past it
        for (int t = 1; t <= MAXO + 2; t++) begin
            wait_phase(0);
            check("R9", int'(ref_urgent), (t >= MAXO) ? 1 : 0);
            check("R2", int'(ref_req), 1);
        end
        // R7 / R9: one grant drains exactly MAX_OWED
        do_grant(1'b0, MAXO, "R7");
        check("R9", int'(ref_urgent), 0);

        // R6: two owed, idle banks, spaced by TRC
        wait_phase(0);
        wait_phase(0);
        check("R9", int'(ref_urgent), 0);
        do_grant(1'b1, 2, "R6");

        // R10: interval expiring inside the row-cycle wait extends the burst
        wait_phase(0);
        wait_phase(IV - 3);
        do_grant(1'b1, 2, "R10");

        // R1: quiet afterwards until next interval
        @(negedge clk);
        check("R8", int'(ref_busy), 0);
        check("R1", cmd_now(), int'(C_DESEL));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule